// File: doc/BRIEF.md
# PSRAM Burst Request Splitter

This block takes one memory-mapped read or write request, given as a start byte address and a byte count. It turns that request into a series of device burst descriptors for an octal-SPI PSRAM command sequencer. Each descriptor carries an opcode, a 24-bit byte address, a 12-bit byte length and a final-burst flag, and it is offered on a valid/ready handshake. The block cuts each burst at the first of three limits: the bytes still owed, the programmable per-burst byte ceiling that keeps chip-select low time within budget, and, for writes only, the next 1024-byte page edge. Linear-burst reads may run across rows, so only the ceiling shortens them.

Requests that the device cannot legally carry are refused in a single cycle with an error pulse, and no descriptor is produced for them. A done pulse marks the handshake of the final descriptor. The wrap length configured in the device is decoded and passed through as a byte count. The block itself always issues linear bursts.

Top module: `psram_burst_split`

## Requirements
- R1: After reset, req_ready is 1 and cmd_valid, done and err are 0.
- R2: A request is refused when its length is 0, its start address is odd, addr+len exceeds 2^24, or it is a write whose length is below 2 or odd. A refused request raises err for exactly one cycle, in the cycle after it is taken. No descriptor follows it, and req_ready stays 1.
- R3: A write descriptor never spans a 1024-byte page edge: (cmd_addr mod 1024) + cmd_len <= 1024. A write that reaches a page edge is split exactly there.
- R4: The burst ceiling L is max_burst with bit 0 cleared, raised to 2 if that gives 0. No descriptor has cmd_len above L.
- R5: Each burst length is the smallest of the remaining bytes, L and (for writes) the distance to the page edge. Consecutive descriptors are contiguous, their lengths sum to the request length, and cmd_last is 1 on the final descriptor only.
- R6: cmd_opcode is 8'h20 for reads. For writes it is 8'h80 when req_wmode=0 and 8'hA0 when req_wmode=1.
- R7: A read is not split at page edges, and a read may have an odd length, including length 1.
- R8: done is 1 for exactly one cycle, the cycle after the final descriptor is accepted. req_ready is 1 in that same cycle, and a new request may be taken then.
- R9: wrap_bytes shows, one cycle after wrap_cfg, the code 0→16, 1→32, 2→64, 3→1024.
- R10: While a request is in progress, req_ready is 0 and req_valid is ignored. No error is raised and the descriptors are unchanged.
- R11: A descriptor holds its fields stable while cmd_valid=1 and cmd_ready=0. Every cmd_addr is even, and every write descriptor has cmd_len >= 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Splitter idle, request taken when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wmode | input | 1 | Write command: 0 synchronous, 1 linear burst |
| req_addr | input | 24 | Start byte address |
| req_len | input | 25 | Length in bytes |
| max_burst | input | 12 | Per-burst byte ceiling from chip-select time budget |
| wrap_cfg | input | 2 | Configured device wrap length code |
| wrap_bytes | output | 11 | Decoded wrap length in bytes |
| err | output | 1 | One-cycle refusal pulse |
| done | output | 1 | One-cycle completion pulse |
| cmd_valid | output | 1 | Descriptor valid |
| cmd_ready | input | 1 | Sequencer accepts descriptor |
| cmd_opcode | output | 8 | Command opcode |
| cmd_addr | output | 24 | Burst start byte address |
| cmd_len | output | 12 | Burst length in bytes |
| cmd_last | output | 1 | Final burst of the request |

## Verification
The completion pulse and the intake of the next request can fall in the same cycle, because the splitter is idle again in the cycle after the final handshake. The bench offers each new request right in the cycle where done is seen high. It then checks that done was a single pulse and that the new request's descriptors, or its error pulse, follow with the expected timing. A second overlap is a request held on req_valid for the whole of a busy period. The bench drops it just before the final handshake and judges that neither an error pulse nor any change to the descriptors results.

// File: rtl/psram_split_pkg.sv
package psram_split_pkg;
  localparam logic [7:0] OP_RD_LINEAR = 8'h20;
  localparam logic [7:0] OP_WR_SYNC   = 8'h80;
  localparam logic [7:0] OP_WR_LINEAR = 8'hA0;

  typedef enum logic {ST_IDLE, ST_BUSY} split_state_t;
endpackage

// File: rtl/psram_req_check.sv
module psram_req_check #(
  parameter int ADDR_W = 24,
  parameter int RLEN_W = 25
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [RLEN_W-1:0] len,
  input  logic              is_write,
  output logic              ok
);
  localparam int SUM_W = (ADDR_W > RLEN_W ? ADDR_W : RLEN_W) + 2;
  localparam logic [SUM_W-1:0] SPACE_TOP = SUM_W'(1) << ADDR_W;

  logic [SUM_W-1:0] end_addr;
  logic             bad_len, bad_align, bad_range, bad_write;

  always_comb begin
    end_addr  = SUM_W'(addr) + SUM_W'(len);
    bad_len   = (len == '0);
    bad_align = addr[0];
    bad_range = (end_addr > SPACE_TOP);
    bad_write = is_write && ((len < RLEN_W'(2)) || len[0]);
    ok        = !(bad_len || bad_align || bad_range || bad_write);
  end
endmodule

// File: rtl/psram_chunk_calc.sv
module psram_chunk_calc #(
  parameter int RLEN_W     = 25,
  parameter int LEN_W      = 12,
  parameter int PAGE_BYTES = 1024
) (
  input  logic [$clog2(PAGE_BYTES)-1:0] page_off,
  input  logic [RLEN_W-1:0]             rem,
  input  logic                          is_write,
  input  logic [LEN_W-1:0]              max_burst,
  output logic [LEN_W-1:0]              chunk,
  output logic                          is_last
);
  localparam int PAGE_LSB = $clog2(PAGE_BYTES);
  localparam int DIST_W   = PAGE_LSB + 1;

  logic [LEN_W-1:0]  ceiling, cap;
  logic [DIST_W-1:0] page_dist;

  always_comb begin
    ceiling = {max_burst[LEN_W-1:1], 1'b0};
    if (ceiling == '0) ceiling = LEN_W'(2);
    page_dist = DIST_W'(PAGE_BYTES) - {1'b0, page_off};
    cap = ceiling;
    if (is_write && (LEN_W'(page_dist) < cap)) cap = LEN_W'(page_dist);
    if (rem <= RLEN_W'(cap)) begin
      chunk   = LEN_W'(rem);
      is_last = 1'b1;
    end else begin
      chunk   = cap;
      is_last = 1'b0;
    end
  end
endmodule

// File: rtl/psram_burst_split.sv
module psram_burst_split
  import psram_split_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int LEN_W      = 12,
  parameter int PAGE_BYTES = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_wmode,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ADDR_W:0]   req_len,
  input  logic [LEN_W-1:0]  max_burst,
  input  logic [1:0]        wrap_cfg,
  output logic [10:0]       wrap_bytes,
  output logic              err,
  output logic              done,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [7:0]        cmd_opcode,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [LEN_W-1:0]  cmd_len,
  output logic              cmd_last
);
  localparam int RLEN_W   = ADDR_W + 1;
  localparam int PAGE_LSB = $clog2(PAGE_BYTES);

  split_state_t      state;
  logic [ADDR_W-1:0] cur_addr;
  logic [RLEN_W-1:0] rem;
  logic              cur_write;
  logic [7:0]        cur_op;
  logic              req_ok;
  logic [LEN_W-1:0]  chunk;
  logic              chunk_last;
  logic [10:0]       wrap_dec;

  psram_req_check #(.ADDR_W(ADDR_W), .RLEN_W(RLEN_W)) u_check (
    .addr(req_addr), .len(req_len), .is_write(req_write), .ok(req_ok)
  );

  psram_chunk_calc #(.RLEN_W(RLEN_W), .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES)) u_calc (
    .page_off(cur_addr[PAGE_LSB-1:0]), .rem(rem), .is_write(cur_write),
    .max_burst(max_burst), .chunk(chunk), .is_last(chunk_last)
  );

  always_comb begin
    case (wrap_cfg)
      2'd0:    wrap_dec = 11'd16;
      2'd1:    wrap_dec = 11'd32;
      2'd2:    wrap_dec = 11'd64;
      default: wrap_dec = 11'd1024;
    endcase
  end

  assign req_ready = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cur_addr   <= '0;
      rem        <= '0;
      cur_write  <= 1'b0;
      cur_op     <= 8'h00;
      cmd_valid  <= 1'b0;
      cmd_opcode <= 8'h00;
      cmd_addr   <= '0;
      cmd_len    <= '0;
      cmd_last   <= 1'b0;
      done       <= 1'b0;
      err        <= 1'b0;
      wrap_bytes <= 11'd16;
    end else begin
      done       <= 1'b0;
      err        <= 1'b0;
      wrap_bytes <= wrap_dec;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            if (!req_ok) begin
              err <= 1'b1;
            end else begin
              cur_addr  <= req_addr;
              rem       <= req_len;
              cur_write <= req_write;
              cur_op    <= !req_write ? OP_RD_LINEAR :
                           (req_wmode ? OP_WR_LINEAR : OP_WR_SYNC);
              state     <= ST_BUSY;
            end
          end
        end
        default: begin
          if (!cmd_valid) begin
            cmd_valid  <= 1'b1;
            cmd_opcode <= cur_op;
            cmd_addr   <= cur_addr;
            cmd_len    <= chunk;
            cmd_last   <= chunk_last;
            cur_addr   <= cur_addr + ADDR_W'(chunk);
            rem        <= rem - RLEN_W'(chunk);
          end else if (cmd_ready) begin
            cmd_valid <= 1'b0;
            if (cmd_last) begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/psram_split_checker.sv
module psram_split_checker #(
  parameter int ADDR_W     = 24,
  parameter int LEN_W      = 12,
  parameter int PAGE_BYTES = 1024
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              done,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [7:0]        cmd_opcode,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [LEN_W-1:0]  cmd_len,
  input logic              cmd_last,
  input logic [LEN_W-1:0]  max_burst
);
  localparam int PAGE_LSB = $clog2(PAGE_BYTES);
  localparam int SPAN_W   = (LEN_W > PAGE_LSB ? LEN_W : PAGE_LSB) + 2;

  logic is_wr;
  assign is_wr = cmd_opcode[7];

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_len)
      && $stable(cmd_opcode) && $stable(cmd_last)); // R11

  AST_EVEN_START: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> !cmd_addr[0]); // R11

  AST_WRITE_MIN: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && is_wr |-> cmd_len >= LEN_W'(2)); // R11

  AST_PAGE_BOUND: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && is_wr |->
      (SPAN_W'(cmd_addr[PAGE_LSB-1:0]) + SPAN_W'(cmd_len)) <= SPAN_W'(PAGE_BYTES)); // R3

  AST_CEILING: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (cmd_len <= max_burst) || (cmd_len == LEN_W'(2))); // R4

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(cmd_valid && cmd_ready && cmd_last)); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !cmd_valid); // R10
endmodule

bind psram_burst_split psram_split_checker #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES)
) u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .done(done),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_opcode(cmd_opcode),
  .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_last(cmd_last),
  .max_burst(max_burst)
);

// File: tb/sim_psram_burst_split.sv
module sim_psram_burst_split;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic        req_wmode = 1'b0;
  logic [23:0] req_addr = '0;
  logic [24:0] req_len = '0;
  logic [11:0] max_burst = 12'd64;
  logic [1:0]  wrap_cfg = 2'd0;
  logic [10:0] wrap_bytes;
  logic        err, done, cmd_valid;
  logic        cmd_ready = 1'b0;
  logic [7:0]  cmd_opcode;
  logic [23:0] cmd_addr;
  logic [11:0] cmd_len;
  logic        cmd_last;

  int checks = 0;
  int failures = 0;

  int          exp_n;
  logic [23:0] exp_addr [512];
  logic [11:0] exp_len  [512];

  psram_burst_split u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_wmode(req_wmode), .req_addr(req_addr),
    .req_len(req_len), .max_burst(max_burst), .wrap_cfg(wrap_cfg),
    .wrap_bytes(wrap_bytes), .err(err), .done(done), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_opcode(cmd_opcode), .cmd_addr(cmd_addr),
    .cmd_len(cmd_len), .cmd_last(cmd_last)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit legal(input bit w, input int a, input int l);
    if (l == 0 || (a % 2) != 0 || a + l > (1 << 24)) return 1'b0;
    if (w && (l < 2 || (l % 2) != 0)) return 1'b0;
    return 1'b1;
  endfunction

  function automatic int exp_op(input bit w, input bit m);
    if (!w) return 32'h20;
    return m ? 32'hA0 : 32'h80;
  endfunction

  task automatic plan_bursts(input bit w, input int a, input int l, input int mb);
    int ceil_b, ea, rl, cap, c;
    ceil_b = mb - (mb % 2);
    if (ceil_b == 0) ceil_b = 2;
    ea = a; rl = l; exp_n = 0;
    while (rl > 0) begin
      cap = ceil_b;
      if (w && (1024 - (ea % 1024)) < cap) cap = 1024 - (ea % 1024);
      c = (rl <= cap) ? rl : cap;
      exp_addr[exp_n] = 24'(ea);
      exp_len[exp_n]  = 12'(c);
      exp_n++;
      ea += c; rl -= c;
    end
  endtask

  // Called in the low phase, after the sample point.
  task automatic run_req(input bit w, input bit m, input int a, input int l,
                         input int mb, input bit intrude);
    int got, guard;
    bit ok;
    ok = legal(w, a, l);
    chk(req_ready == 1'b1, "R8 ready at issue", int'(req_ready), 1);
    max_burst = 12'(mb);
    req_write = w; req_wmode = m; req_addr = 24'(a); req_len = 25'(l);
    req_valid = 1'b1;
    @(negedge clk); #2;
    if (intrude) begin
      req_len = '0;
    end else begin
      req_valid = 1'b0;
    end
    if (!ok) begin
      chk(err == 1'b1, "R2 err pulse", int'(err), 1);
      chk(req_ready == 1'b1, "R2 ready kept", int'(req_ready), 1);
      req_valid = 1'b0;
      for (int i = 0; i < 3; i++) begin
        @(negedge clk); #2;
        chk(cmd_valid == 1'b0, "R2 no descriptor", int'(cmd_valid), 0);
        chk(err == 1'b0, "R2 err one cycle", int'(err), 0);
      end
      return;
    end
    plan_bursts(w, a, l, mb);
    chk(err == 1'b0, "R2 legal no err", int'(err), 0);
    chk(req_ready == 1'b0, "R10 busy not ready", int'(req_ready), 0);
    got = 0; guard = 0;
    while (got < exp_n && guard < 20000) begin
      cmd_ready = ($urandom % 4) != 0;
      chk(done == 1'b0, "R8 no early done", int'(done), 0);
      if (intrude) chk(err == 1'b0, "R10 intrusion ignored", int'(err), 0);
      if (cmd_valid && cmd_ready) begin
        chk(cmd_addr == exp_addr[got], "R5 addr", int'(cmd_addr), int'(exp_addr[got]));
        chk(cmd_len == exp_len[got], w ? "R3 write len" : "R7 read len",
            int'(cmd_len), int'(exp_len[got]));
        chk(int'(cmd_opcode) == exp_op(w, m), "R6 opcode", int'(cmd_opcode), exp_op(w, m));
        chk(cmd_last == (got == exp_n - 1), "R5 last flag", int'(cmd_last),
            int'(got == exp_n - 1));
        if (cmd_last) req_valid = 1'b0;
        got++;
      end
      @(negedge clk); #2;
      guard++;
    end
    cmd_ready = 1'b0;
    chk(got == exp_n, "R5 burst count", got, exp_n);
    chk(done == 1'b1, "R8 done pulse", int'(done), 1);
    chk(req_ready == 1'b1, "R8 ready with done", int'(req_ready), 1);
    chk(cmd_valid == 1'b0, "R5 no extra descriptor", int'(cmd_valid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd7351));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0; #2;
    chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
    chk(cmd_valid == 1'b0, "R1 cmd_valid", int'(cmd_valid), 0);
    chk(done == 1'b0, "R1 done", int'(done), 0);
    chk(err == 1'b0, "R1 err", int'(err), 0);

    for (int v = 0; v < 4; v++) begin
      wrap_cfg = 2'(v);
      @(negedge clk); #2;
      chk(int'(wrap_bytes) == (v == 3 ? 1024 : (16 << v)), "R9 wrap",
          int'(wrap_bytes), (v == 3 ? 1024 : (16 << v)));
    end

    run_req(1, 1, 24'h3FE, 6, 4094, 0);      // R3 split at page edge
    run_req(1, 0, 4, 1024, 4094, 0);         // R3 unaligned full page
    run_req(0, 0, 24'h3FE, 2000, 4094, 0);   // R7 read across page
    run_req(0, 0, 24'h10, 7, 4, 0);          // R7 odd read, R4
    run_req(0, 0, 0, 5, 1, 0);               // R4 ceiling raised to 2
    run_req(1, 0, 0, 14, 7, 0);              // R4 odd ceiling cleared
    run_req(0, 0, 24'h20, 1, 64, 0);         // R7 single byte read
    run_req(0, 1, 24'hFFFFF0, 16, 64, 0);    // R2 ends exactly at top
    run_req(0, 0, 24'hFFFFF0, 17, 64, 0);    // R2 past top
    run_req(0, 0, 24'h100, 0, 64, 0);        // R2 zero length
    run_req(0, 0, 24'h101, 8, 64, 0);        // R2 odd start
    run_req(1, 0, 24'h100, 1, 64, 0);        // R2 write below 2
    run_req(1, 1, 24'h100, 3, 64, 0);        // R2 odd write length
    run_req(1, 1, 24'h7F8, 40, 16, 1);       // R10 request held during busy
    run_req(0, 0, 24'h40, 10, 64, 0);        // R10 state untouched after intrusion

    for (int n = 0; n < 40; n++) begin
      bit w;
      int a, l, mb;
      w = 1'($urandom % 2);
      a = ($urandom % 6000) * 2;
      if ($urandom % 3 == 0) a = 1024 * (1 + $urandom % 5) - 2 * (1 + $urandom % 8);
      l = w ? 2 * (1 + $urandom % 1500) : 1 + $urandom % 3000;
      mb = 16 + $urandom % 4080;
      if ($urandom % 8 == 0) l = 0;
      run_req(w, 1'($urandom % 2), a, l, mb, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule